// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running calendar clock and raises an alarm when the current time agrees with a programmed alarm setting. Five fields take part: seconds, minutes, hours, day of month and month. Every field holds two-digit BCD. Each alarm field has its own skip bit. A skip bit of 0 means the field must equal the current time. A skip bit of 1 removes the field from the comparison. Choosing which fields to compare sets how often the alarm repeats. With nothing compared it fires every second. Comparing only seconds gives once per minute. Adding minutes gives once per hour, adding hours gives once per day, and adding the day of month gives once per month.

The timekeeper supplies a one-second strobe in the same cycle that its time outputs show the newly advanced value. The comparison is made only on that strobe, so each matching second gives exactly one pulse, one cycle later. The same registered decision sets a sticky flag. The flag stays set until software pulses the clear input. All pins are plain level or strobe signals. The block has no streaming data path and therefore no valid/ready handshake and no back-pressure.

Top module: `cal_alarm_match`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, alarm_pulse and alarm_flag are both 0.
- R2: alarm_pulse is high for one cycle, in the cycle after a cycle where sec_tick was high and the enabled fields matched. Without sec_tick, alarm_pulse stays 0 however the fields compare.
- R3: A field whose skip bit is 0 must equal the current time for a match. A field whose skip bit is 1 has no effect on the match.
- R4: With all five skip bits at 1, every sec_tick produces a pulse.
- R5: With only seconds compared (alarm second 30), a clock that runs from 00:00:00 for 200 seconds produces exactly 3 pulses, one per minute.
- R6: With seconds and minutes compared (alarm at minute 15, second 30), a clock that runs from 00:00:00 for 7200 seconds produces exactly 2 pulses, one per hour.
- R7: Only the valid low bits of each byte are compared: 7 bits for seconds and minutes, 6 bits for hours and day of month, and 5 bits for month. Higher bits in the time inputs or the alarm inputs are ignored.
- R8: alarm_flag goes high in the same cycle as alarm_pulse. It stays high until flag_clr is sampled high.
- R9: flag_clr sampled high clears alarm_flag in the next cycle. If a new match is decided in the same cycle as the clear, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second strobe, high in the cycle the time fields show the new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_month | input | 8 | Alarm month, BCD |
| skip_sec | input | 1 | 1 removes seconds from the comparison |
| skip_min | input | 1 | 1 removes minutes from the comparison |
| skip_hour | input | 1 | 1 removes hours from the comparison |
| skip_date | input | 1 | 1 removes day of month from the comparison |
| skip_month | input | 1 | 1 removes month from the comparison |
| flag_clr | input | 1 | Clears the sticky flag |
| alarm_pulse | output | 1 | One-cycle alarm strobe |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The comparison is tried in four ways. First, a free-running clock with no fields compared, which separates per-tick firing from a stuck output. Second, the same clock with only seconds compared, and third, with seconds and minutes compared; these two show that each added field lowers the repeat rate. Fourth, a fixed time with one field at a time mismatched or skipped, with junk in the unused high bits; this shows that every field gates the match and that the masking is correct. Matching time held with no strobe shows that the strobe gates the pulse. A clear issued alone, and a clear issued together with a new match, show the flag's priority rule.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD = 5;

  typedef enum int {
    F_SEC   = 0,
    F_MIN   = 1,
    F_HOUR  = 2,
    F_DATE  = 3,
    F_MONTH = 4
  } field_e;

  // Meaningful BCD bit count of each calendar field
  function automatic int field_width(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 7;
      F_HOUR, F_DATE: return 6;
      default:        return 5;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field #(
  parameter int BYTE_W  = 8,
  parameter int VALID_W = 7
) (
  input  logic [BYTE_W-1:0] now_val,
  input  logic [BYTE_W-1:0] alm_val,
  input  logic              skip,
  output logic              hit
);
  localparam logic [BYTE_W-1:0] MASK = BYTE_W'((1 << VALID_W) - 1);

  // Compare BCD digits in place; bits above the field are masked off
  always_comb begin
    hit = skip | (((now_val ^ alm_val) & MASK) == '0);
  end
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic all_hit,
  input  logic flag_clr,
  output logic alarm_pulse,
  output logic alarm_flag
);
  logic fire;
  assign fire = sec_tick & all_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_pulse <= 1'b0;
      alarm_flag  <= 1'b0;
    end else begin
      alarm_pulse <= fire;
      if (fire)          alarm_flag <= 1'b1;
      else if (flag_clr) alarm_flag <= 1'b0;
    end
  end

  assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(sec_tick));

  assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> alarm_flag);

  assert_flag_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> alarm_pulse);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alarm_flag) && !$past(flag_clr)) |-> alarm_flag);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_clr) && !alarm_pulse) |-> !alarm_flag);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] now_sec,
  input  logic [BYTE_W-1:0] now_min,
  input  logic [BYTE_W-1:0] now_hour,
  input  logic [BYTE_W-1:0] now_date,
  input  logic [BYTE_W-1:0] now_month,
  input  logic [BYTE_W-1:0] alm_sec,
  input  logic [BYTE_W-1:0] alm_min,
  input  logic [BYTE_W-1:0] alm_hour,
  input  logic [BYTE_W-1:0] alm_date,
  input  logic [BYTE_W-1:0] alm_month,
  input  logic              skip_sec,
  input  logic              skip_min,
  input  logic              skip_hour,
  input  logic              skip_date,
  input  logic              skip_month,
  input  logic              flag_clr,
  output logic              alarm_pulse,
  output logic              alarm_flag
);
  logic [NFIELD-1:0][BYTE_W-1:0] now_f, alm_f;
  logic [NFIELD-1:0]             skip_f, hit_f;
  logic                          all_hit;

  assign now_f  = {now_month, now_date, now_hour, now_min, now_sec};
  assign alm_f  = {alm_month, alm_date, alm_hour, alm_min, alm_sec};
  assign skip_f = {skip_month, skip_date, skip_hour, skip_min, skip_sec};

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    cal_alarm_field #(
      .BYTE_W (BYTE_W),
      .VALID_W(field_width(i))
    ) u_field (
      .now_val(now_f[i]),
      .alm_val(alm_f[i]),
      .skip   (skip_f[i]),
      .hit    (hit_f[i])
    );
  end

  assign all_hit = &hit_f;

  cal_alarm_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .all_hit    (all_hit),
    .flag_clr   (flag_clr),
    .alarm_pulse(alarm_pulse),
    .alarm_flag (alarm_flag)
  );

  assert_pulse_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !all_hit) |=> !alarm_pulse);

  assert_all_skip_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && (&skip_f)) |=> alarm_pulse);
endmodule

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 8'h01, now_month = 8'h01;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0, alm_date = 0, alm_month = 0;
  logic skip_sec = 1, skip_min = 1, skip_hour = 1, skip_date = 1, skip_month = 1;
  logic flag_clr = 1'b0;
  logic alarm_pulse, alarm_flag;

  int checks = 0, fails = 0, pulses = 0;
  string phase = "R1";
  logic exp_pulse = 1'b0, exp_flag = 1'b0;
  int s = 0, m = 0, h = 0, d = 1, mo = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_match u_dut (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic bit fld_ok(input bit skip, input int a, input int b, input int span);
    return skip || ((a % span) == (b % span));
  endfunction

  function automatic bit model_hit();
    return fld_ok(skip_sec, now_sec, alm_sec, 128) && fld_ok(skip_min, now_min, alm_min, 128) &&
           fld_ok(skip_hour, now_hour, alm_hour, 64) && fld_ok(skip_date, now_date, alm_date, 64) &&
           fld_ok(skip_month, now_month, alm_month, 32);
  endfunction

  // Behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_pulse <= 1'b0;
      exp_flag  <= 1'b0;
    end else begin
      exp_pulse <= sec_tick && model_hit();
      if (sec_tick && model_hit()) exp_flag <= 1'b1;
      else if (flag_clr)           exp_flag <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({phase, " pulse"}, alarm_pulse, exp_pulse);
    chk({phase, " flag"}, alarm_flag, exp_flag);
    if (alarm_pulse) pulses++;
  end

  task automatic drive_time();
    now_sec = to_bcd(s); now_min = to_bcd(m); now_hour = to_bcd(h);
    now_date = to_bcd(d); now_month = to_bcd(mo);
  endtask

  task automatic advance();
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) begin h = 0; d++; end
    if (d == 29) begin d = 1; mo++; end
    if (mo == 13) mo = 1;
  endtask

  task automatic tick_once();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic run_clock(input int n);
    s = 0; m = 0; h = 0; d = 1; mo = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance(); drive_time(); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 pulse in reset", alarm_pulse, 0);
    chk("R1 flag in reset", alarm_flag, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", alarm_pulse, 0);

    phase = "R4";
    pulses = 0;
    run_clock(10);
    chk("R4 every tick fires", pulses, 10);

    phase = "R5";
    skip_sec = 0; alm_sec = 8'h30;
    pulses = 0;
    run_clock(200);
    chk("R5 once per minute", pulses, 3);

    phase = "R6";
    skip_min = 0; alm_min = 8'h15;
    pulses = 0;
    run_clock(7200);
    chk("R6 once per hour", pulses, 2);

    // Fixed time 12:34:56, day 15, month 07, all fields compared, junk high bits
    phase = "R7";
    now_sec = 8'h56; now_min = 8'h34; now_hour = 8'hD2; now_date = 8'h55; now_month = 8'hE7;
    alm_sec = 8'hD6; alm_min = 8'hB4; alm_hour = 8'h52; alm_date = 8'h95; alm_month = 8'h27;
    skip_sec = 0; skip_min = 0; skip_hour = 0; skip_date = 0; skip_month = 0;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    pulses = 0;
    tick_once(); @(negedge clk);
    chk("R7 high bits ignored", pulses, 1);

    phase = "R2";
    pulses = 0;
    repeat (6) @(negedge clk);
    chk("R2 no tick no pulse", pulses, 0);

    phase = "R3";
    alm_month = 8'h08; pulses = 0;
    tick_once(); @(negedge clk);
    chk("R3 month mismatch blocks", pulses, 0);
    alm_month = 8'h07; alm_date = 8'h16;
    tick_once(); @(negedge clk);
    chk("R3 date mismatch blocks", pulses, 0);
    alm_date = 8'h15; alm_hour = 8'h13;
    tick_once(); @(negedge clk);
    chk("R3 hour mismatch blocks", pulses, 0);
    skip_hour = 1;
    tick_once(); @(negedge clk);
    chk("R3 skipped hour ignored", pulses, 1);

    phase = "R8";
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", alarm_flag, 1);

    phase = "R9";
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R9 clear", alarm_flag, 0);
    @(negedge clk);
    sec_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; flag_clr = 1'b0;
    chk("R9 match beats clear", alarm_flag, 1);
    chk("R9 pulse with clear", alarm_pulse, 1);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule